// File: doc/BRIEF.md
# Sample Pair Packer and Burst Writer

This block sits between a 12-bit sample stream and a memory controller. The memory controller is reached through a Wishbone-style master port. While the capture-enable input is high, the block takes one sample per clock. It joins each two consecutive samples into a 24-bit word and queues the words in a local FIFO. An incomplete pair is thrown away when capture-enable drops.

A drain engine watches the FIFO level. When the level is above the start threshold, it opens a bus cycle and writes a block of eight words as one burst. The write address starts at zero, advances one word per acknowledge and wraps at the end of the configured buffer. After the eighth acknowledge the block pulses a done output, so that a downstream counter can track stored blocks. If a word arrives while the FIFO is full, the word is lost and a sticky error flag is set. Only reset clears the flag.

Everything runs on one clock with a synchronous, active-high reset.

Top module: `pair_pack_burst_wr`

## Requirements
- R1: While reset is high, at the next clock edge `wbCyc`, `wbStb`, `blockDone` and `ovfErr` go low and `wbAdr` goes to 0.
- R2: Each memory word carries the first sample of its pair in bits [11:0] and the second sample in bits [23:12]. Bits [31:24] are zero.
- R3: Samples are taken only on clocks where `captureEn` is high. Two consecutive captured samples form one word. A single captured sample left over when `captureEn` falls produces no word.
- R4: A burst begins only when the FIFO holds more than 8 words. With exactly 8 words queued, the bus stays idle.
- R5: A burst holds `wbCyc`, `wbStb` and `wbWe` high until exactly 8 acknowledges have been received. Address and data stay stable on every clock where `wbAck` is low.
- R6: The first write after reset goes to address 0. The address rises by one on each acknowledge and wraps from `BUF_WORDS-1` (63 by default) to 0.
- R7: `blockDone` is high for exactly one clock, in the clock after the eighth acknowledge of a burst, and `wbCyc` is low in that clock.
- R8: A word produced while the FIFO is full sets `ovfErr`. The flag stays high whatever follows, until reset.
- R9: Words reach memory in the order their pairs were captured, with none skipped or repeated while no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for sampling and the bus |
| rst | input | 1 | Synchronous reset, active high |
| captureEn | input | 1 | High on clocks whose sample is taken |
| sampleIn | input | 12 | Sample value for the current clock |
| wbCyc | output | 1 | Bus cycle held for a whole burst |
| wbStb | output | 1 | Transfer strobe |
| wbWe | output | 1 | Write enable (always a write) |
| wbAdr | output | 6 | Word address inside the buffer |
| wbDat | output | 32 | Write data: packed pair, upper byte zero |
| wbAck | input | 1 | Acknowledge from the memory side |
| blockDone | output | 1 | One-clock pulse per stored block of 8 words |
| ovfErr | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench goes after the threshold boundary. With exactly eight words queued, a design that compares with at-least instead of more-than starts a burst and writes too many words. With nine words queued, a design that waits too long writes nothing.

Odd-length captures and one-sample captures check the discarding rule. A packer that keeps a stale half-pair would shift every later word and break the data order.

Acknowledges are withheld on a fixed pattern to catch two faults: a burst that releases the bus early, and a burst that moves the address or data while stalled. Enough words are written to cross the wrap point, which exposes an address that runs past the buffer. A flood with acknowledges held off shows whether the error flag latches and stays high until reset.

// File: rtl/ppbw_pkg.sv
package ppbw_pkg;

  // Strobes from the drain control to the datapath
  typedef struct packed {
    logic popWord;   // head word accepted by the bus
    logic advAdr;    // step the write address
  } ctlStrobes_t;

  typedef enum logic {
    DRAIN_IDLE  = 1'b0,
    DRAIN_BURST = 1'b1
  } drainState_t;

endpackage

// File: rtl/ppbw_fifo.sv
module ppbw_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level,
  output logic             dropped
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isFull, isEmpty, doPush, doPop;

  assign isFull  = (level == LVL_W'(DEPTH));
  assign isEmpty = (level == '0);
  assign doPop   = pop && !isEmpty;
  // a full FIFO still accepts a word when the head leaves in the same clock
  assign doPush  = push && (!isFull || doPop);
  assign dropped = push && !doPush;
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/ppbw_datapath.sv
module ppbw_datapath
  import ppbw_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int BUS_W      = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int BUF_WORDS  = 64,
  localparam int PAIR_W = 2 * SAMPLE_W,
  localparam int PAD_W  = BUS_W - PAIR_W,
  localparam int ADR_W  = $clog2(BUF_WORDS),
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                captureEn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  ctlStrobes_t         strobes,
  output logic [LVL_W-1:0]    fifoLevel,
  output logic [ADR_W-1:0]    wbAdr,
  output logic [BUS_W-1:0]    wbDat,
  output logic                ovfErr
);

  logic                haveFirst;
  logic [SAMPLE_W-1:0] heldSample;
  logic                pushWord;
  logic [PAIR_W-1:0]   pairWord, headWord;
  logic                fifoDropped;

  // Pair assembly: the first sample waits in a register, the second completes the word
  always_ff @(posedge clk) begin
    if (rst) begin
      haveFirst  <= 1'b0;
      heldSample <= '0;
    end else if (!captureEn) begin
      haveFirst <= 1'b0;          // a half pair is dropped
    end else begin
      haveFirst <= !haveFirst;
      if (!haveFirst) heldSample <= sampleIn;
    end
  end

  assign pushWord = captureEn && haveFirst;
  assign pairWord = {sampleIn, heldSample};

  ppbw_fifo #(
    .WIDTH (PAIR_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (pushWord),
    .pushData (pairWord),
    .pop      (strobes.popWord),
    .headData (headWord),
    .level    (fifoLevel),
    .dropped  (fifoDropped)
  );

  // Padding to the bus width is applied only at the output
  generate
    if (PAD_W > 0) begin : g_pad
      assign wbDat = {{PAD_W{1'b0}}, headWord};
    end else begin : g_nopad
      assign wbDat = headWord[BUS_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wbAdr <= '0;
    end else if (strobes.advAdr) begin
      wbAdr <= (wbAdr == ADR_W'(BUF_WORDS - 1)) ? '0 : wbAdr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ovfErr <= 1'b0;
    else if (fifoDropped) ovfErr <= 1'b1;
  end

endmodule

// File: rtl/ppbw_ctrl.sv
module ppbw_ctrl
  import ppbw_pkg::*;
#(
  parameter int BURST_LEN   = 8,
  parameter int START_LEVEL = 8,
  parameter int LVL_W       = 6,
  localparam int BEAT_W = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             wbAck,
  output logic             wbCyc,
  output logic             wbStb,
  output logic             wbWe,
  output logic             blockDone,
  output ctlStrobes_t      strobes
);

  drainState_t       state;
  logic [BEAT_W-1:0] beatCnt;
  logic              inBurst, beatTaken, lastBeat;

  assign inBurst   = (state == DRAIN_BURST);
  assign beatTaken = inBurst && wbAck;
  assign lastBeat  = (beatCnt == BEAT_W'(BURST_LEN - 1));

  assign wbCyc = inBurst;
  assign wbStb = inBurst;
  assign wbWe  = inBurst;

  always_comb begin
    strobes         = '0;
    strobes.popWord = beatTaken;
    strobes.advAdr  = beatTaken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= DRAIN_IDLE;
      beatCnt   <= '0;
      blockDone <= 1'b0;
    end else begin
      blockDone <= 1'b0;
      case (state)
        DRAIN_IDLE: begin
          if (fifoLevel > LVL_W'(START_LEVEL)) begin
            state   <= DRAIN_BURST;
            beatCnt <= '0;
          end
        end
        DRAIN_BURST: begin
          if (beatTaken) begin
            if (lastBeat) begin
              state     <= DRAIN_IDLE;
              blockDone <= 1'b1;
            end
            beatCnt <= beatCnt + 1'b1;
          end
        end
        default: state <= DRAIN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pair_pack_burst_wr.sv
module pair_pack_burst_wr
  import ppbw_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int BUS_W       = 32,
  parameter int FIFO_DEPTH  = 32,
  parameter int BURST_LEN   = 8,
  parameter int START_LEVEL = 8,
  parameter int BUF_WORDS   = 64,
  localparam int ADR_W = $clog2(BUF_WORDS),
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                captureEn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                wbCyc,
  output logic                wbStb,
  output logic                wbWe,
  output logic [ADR_W-1:0]    wbAdr,
  output logic [BUS_W-1:0]    wbDat,
  input  logic                wbAck,
  output logic                blockDone,
  output logic                ovfErr
);

  ctlStrobes_t      strobes;
  logic [LVL_W-1:0] fifoLevel;

  ppbw_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .BUS_W      (BUS_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .BUF_WORDS  (BUF_WORDS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .captureEn (captureEn),
    .sampleIn  (sampleIn),
    .strobes   (strobes),
    .fifoLevel (fifoLevel),
    .wbAdr     (wbAdr),
    .wbDat     (wbDat),
    .ovfErr    (ovfErr)
  );

  ppbw_ctrl #(
    .BURST_LEN   (BURST_LEN),
    .START_LEVEL (START_LEVEL),
    .LVL_W       (LVL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fifoLevel (fifoLevel),
    .wbAck     (wbAck),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .wbWe      (wbWe),
    .blockDone (blockDone),
    .strobes   (strobes)
  );

endmodule

// File: rtl/ppbw_chk.sv
module ppbw_chk #(
  parameter int BUS_W     = 32,
  parameter int PAIR_W    = 24,
  parameter int BURST_LEN = 8,
  parameter int BUF_WORDS = 64,
  localparam int ADR_W = $clog2(BUF_WORDS),
  localparam int CNT_W = $clog2(BURST_LEN + 1) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wbCyc,
  input logic             wbStb,
  input logic             wbWe,
  input logic [ADR_W-1:0] wbAdr,
  input logic [BUS_W-1:0] wbDat,
  input logic             wbAck,
  input logic             blockDone,
  input logic             ovfErr
);

  logic [CNT_W-1:0] ackSeen;

  always_ff @(posedge clk) begin
    if (rst || blockDone)            ackSeen <= '0;
    else if (wbCyc && wbStb && wbAck) ackSeen <= ackSeen + 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!wbCyc && !wbStb && !blockDone && !ovfErr && wbAdr == '0));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    wbCyc |-> (wbDat[BUS_W-1:PAIR_W] == '0));

  a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck) |=>
      (wbCyc && wbStb && wbWe && $stable(wbAdr) && $stable(wbDat)));

  a_r5_eight_beats: assert property (@(posedge clk) disable iff (rst)
    blockDone |-> (ackSeen == CNT_W'(BURST_LEN)));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && wbAck) |=>
      (wbAdr == (($past(wbAdr) == ADR_W'(BUF_WORDS - 1)) ? '0 : $past(wbAdr) + 1'b1)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    blockDone |=> !blockDone);

  a_r7_bus_released: assert property (@(posedge clk) disable iff (rst)
    blockDone |-> (!wbCyc && $past(wbCyc && wbAck)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    ovfErr |=> ovfErr);

endmodule

bind pair_pack_burst_wr ppbw_chk #(
  .BUS_W     (BUS_W),
  .PAIR_W    (2 * SAMPLE_W),
  .BURST_LEN (BURST_LEN),
  .BUF_WORDS (BUF_WORDS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wbCyc     (wbCyc),
  .wbStb     (wbStb),
  .wbWe      (wbWe),
  .wbAdr     (wbAdr),
  .wbDat     (wbDat),
  .wbAck     (wbAck),
  .blockDone (blockDone),
  .ovfErr    (ovfErr)
);

// File: tb/sim_pair_pack_burst_wr.sv
module sim_pair_pack_burst_wr;

  localparam int SW    = 12;
  localparam int BW    = 32;
  localparam int DEPTH = 32;
  localparam int BURST = 8;
  localparam int THR   = 8;
  localparam int BUFW  = 64;
  localparam int AW    = $clog2(BUFW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          captureEn = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic          wbCyc, wbStb, wbWe, wbAck, blockDone, ovfErr;
  logic [AW-1:0] wbAdr;
  logic [BW-1:0] wbDat;
  logic          ackGate = 1'b0;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [BW-1:0] expWords [0:1023];
  int            expCount = 0;
  logic          modelHave = 1'b0;
  logic [SW-1:0] modelFirst = '0;
  int            sampleSeed = 0;
  int            ackMode = 0;   // 0 always, 1 stalled pattern, 2 never
  logic          skipData = 1'b0;

  // monitor state
  int   recCount = 0;
  int   doneCount = 0;
  int   beatsSince = 0;
  int   cycleNo = 0;
  logic prevDone = 1'b0;
  logic wrapSeen = 1'b0;

  always #10 clk = ~clk;

  assign wbAck = wbCyc & wbStb & ackGate;

  pair_pack_burst_wr #(
    .SAMPLE_W (SW), .BUS_W (BW), .FIFO_DEPTH (DEPTH),
    .BURST_LEN (BURST), .START_LEVEL (THR), .BUF_WORDS (BUFW)
  ) u0 (
    .clk (clk), .rst (rst), .captureEn (captureEn), .sampleIn (sampleIn),
    .wbCyc (wbCyc), .wbStb (wbStb), .wbWe (wbWe), .wbAdr (wbAdr),
    .wbDat (wbDat), .wbAck (wbAck), .blockDone (blockDone), .ovfErr (ovfErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int drained(input int w);
    if (w <= THR) return 0;
    return BURST * ((w - THR + BURST - 1) / BURST);
  endfunction

  // Monitor: acts at the falling edge, where all outputs are settled
  always @(negedge clk) begin
    cycleNo++;
    case (ackMode)
      0:       ackGate = 1'b1;
      1:       ackGate = (cycleNo % 3 == 0);
      default: ackGate = 1'b0;
    endcase
    if (rst) begin
      recCount   = 0;
      doneCount  = 0;
      beatsSince = 0;
      prevDone   = 1'b0;
    end else begin
      if (blockDone) begin
        doneCount++;
        check(beatsSince == BURST, "R5", "beats in burst", beatsSince, BURST);
        check(!wbCyc, "R7", "bus low with done pulse", wbCyc, 0);
        check(!prevDone, "R7", "done pulse width", prevDone, 0);
        beatsSince = 0;
      end
      prevDone = blockDone;
      if (wbCyc && wbStb && ackGate) begin
        if (!skipData) begin
          check(wbDat == expWords[recCount], "R9", "word order/data",
                wbDat, expWords[recCount]);
          check(wbDat[BW-1:2*SW] == '0, "R2", "upper byte", wbDat[BW-1:2*SW], 0);
          check(wbAdr == AW'(recCount % BUFW), "R6", "write address",
                wbAdr, recCount % BUFW);
          if (recCount == BUFW && wbAdr == '0) wrapSeen = 1'b1;
        end
        recCount++;
        beatsSince++;
      end
    end
  end

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleSeed++;
      captureEn = 1'b1;
      sampleIn  = SW'(sampleSeed * 1103 + 7);
      if (modelHave) begin
        expWords[expCount] = {{(BW-2*SW){1'b0}}, sampleIn, modelFirst};
        expCount++;
        modelHave = 1'b0;
      end else begin
        modelFirst = sampleIn;
        modelHave  = 1'b1;
      end
    end
    @(negedge clk);
    captureEn = 1'b0;
    sampleIn  = ~sampleIn;
    modelHave = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      captureEn = 1'b0;
      sampleIn  = SW'(i * 77 + 5);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    captureEn = 1'b0;
    idle(3);
    check(!wbCyc && !wbStb, "R1", "bus idle in reset", wbCyc, 0);
    check(!blockDone, "R1", "done low in reset", blockDone, 0);
    check(!ovfErr, "R1", "error clear in reset", ovfErr, 0);
    check(wbAdr == '0, "R1", "address zero in reset", wbAdr, 0);
    expCount  = 0;
    modelHave = 1'b0;
    skipData  = 1'b0;
    wrapSeen  = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_threshold();
    ackMode = 0;
    capture(2 * THR);                       // exactly 8 words
    idle(40);
    check(recCount == 0, "R4", "no burst at 8 words", recCount, 0);
    capture(2);                             // ninth word
    idle(40);
    check(recCount == BURST, "R4", "burst at 9 words", recCount, BURST);
    check(doneCount == 1, "R7", "one done pulse", doneCount, 1);
  endtask

  task automatic t_pairs();
    ackMode = 0;
    capture(5);       // 2 words, one sample dropped
    idle(3);
    capture(1);       // lone sample, dropped
    idle(2);
    capture(7);       // 3 words, one sample dropped
    idle(1);
    capture(40);
    idle(60);
    check(recCount == drained(expCount), "R3", "words after odd captures",
          recCount, drained(expCount));
  endtask

  task automatic t_stall();
    ackMode = 1;
    capture(80);
    idle(150);
    check(recCount == drained(expCount), "R5", "words with stalled acks",
          recCount, drained(expCount));
    check(doneCount == recCount / BURST, "R7", "done pulses per block",
          doneCount, recCount / BURST);
    ackMode = 0;
  endtask

  task automatic t_wrap();
    ackMode = 0;
    capture(60);
    idle(60);
    check(recCount > BUFW, "R6", "enough writes to wrap", recCount, BUFW + 1);
    check(wrapSeen, "R6", "address wrapped to 0", wrapSeen, 1);
    check(!ovfErr, "R8", "no error without overflow", ovfErr, 0);
  endtask

  task automatic t_overflow();
    ackMode  = 2;
    skipData = 1'b1;
    capture(2 * (DEPTH + 10));
    idle(2);
    check(ovfErr, "R8", "error after overflow", ovfErr, 1);
    ackMode = 0;
    idle(60);
    check(ovfErr, "R8", "error stays set", ovfErr, 1);
    doReset();
    check(!ovfErr, "R8", "reset clears error", ovfErr, 0);
    capture(2 * 18);
    idle(60);
    check(recCount == 16, "R6", "writes restart after reset", recCount, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    t_threshold();
    t_pairs();
    t_stall();
    t_wrap();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule